// File: doc/BRIEF.md
# Edge-Selectable Timer Capture Unit

This block timestamps transitions on one external input. A free-running timebase counter advances by one on every clock while its run bit is set. When the input makes a transition of a kind that the mode register enables, the counter value is copied into a capture register. A sticky event flag is then raised and may drive an interrupt request. Rising edges, falling edges or both can be enabled, each with its own bit.

The input is asynchronous. It passes through a synchroniser and then a stability filter. A new level is accepted only after it has held for two consecutive clocks, so shorter pulses never reach the edge detector. The accepted level is brought out as a status bit. When both edges are enabled, software can read it after a capture to tell which way the input moved. The event flag is cleared only by a software write, and it is never cleared as a side effect of servicing the interrupt.

Software talks to the block through a small write port with two registers. The mode register is at address 0. The control register is at address 1: bit 1 is the timebase run enable, and writing 0 to bit 0 clears the event flag.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset, the timebase, the capture value, the event flag, the interrupt request, the mode register, the run bit and the filtered level are all 0.
- R2: The timebase increments by one each clock while the run bit (control bit 1) is 1, holds its value while the run bit is 0, and wraps from 0xFFFF to 0x0000.
- R3: With mode bit 5 set and mode bit 4 clear, a low-to-high transition of the filtered input causes a capture and a high-to-low transition does not.
- R4: With mode bit 4 set and mode bit 5 clear, a high-to-low transition causes a capture and a low-to-high transition does not.
- R5: With mode bits 5 and 4 both set, transitions in either direction cause a capture.
- R6: With mode bits 5 and 4 both clear, no transition causes a capture.
- R7: A new input level is accepted only after it has been present at the synchroniser output for 2 consecutive clocks. A pulse lasting one clock is ignored. The pin_level output shows the accepted level.
- R8: When an input change is first sampled at clock edge k, the event flag rises at edge k+4. The capture value then equals the timebase value that was visible in the cycle before the flag rose.
- R9: The event flag stays at 1 until a write to address 1 with data bit 0 equal to 0. Writes with bit 0 equal to 1, and writes to other addresses, leave the flag unchanged.
- R10: If a capture and a flag-clearing write happen in the same cycle, the flag is 1 afterwards.
- R11: irq is 1 exactly when the event flag is 1 and mode bit 0 is 1.
- R12: The capture value changes only in a cycle in which a capture occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 1 | Asynchronous external input being watched |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 mode, 1 control) |
| wr_data | input | 8 | Register write data |
| mode_q | output | 8 | Current mode register contents |
| run_q | output | 1 | Timebase run enable |
| timebase | output | 16 | Free-running timebase count |
| cap_value | output | 16 | Last captured timebase value |
| cap_flag | output | 1 | Sticky capture event flag |
| irq | output | 1 | Interrupt request |
| pin_level | output | 1 | Filtered input level |

## Verification
The bench builds the block with its default parameters: a 16-bit timebase, two synchroniser stages and a two-clock stability window. With the two-clock window, a one-clock pulse and a two-clock pulse can be driven one cycle apart, which exercises both sides of the filter boundary. With the 16-bit counter, the wrap from 0xFFFF can be reached by letting the timebase run for about 65,000 cycles. The fixed five-edge latency lets the bench line up a clearing write with the capture cycle, which tests the case where the two coincide.

// File: rtl/capt_pkg.sv
// Package: shared types and register layout for the edge capture unit.
// Assumes an 8-bit register data path; the mode bit order is fixed.
package capt_pkg;

    localparam int MODE_W = 8;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_MODE = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd1;

    localparam int CTRL_FLAG_BIT = 0;
    localparam int CTRL_RUN_BIT  = 1;

    // Mode register layout, most significant bit first.
    typedef struct packed {
        logic wide_pwm;
        logic cmp_en;
        logic rise_en;
        logic fall_en;
        logic match_en;
        logic toggle_en;
        logic pwm_en;
        logic int_en;
    } mode_t;

    // Kind of transition seen on the filtered input this cycle.
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_RISE = 2'd1,
        EV_FALL = 2'd2
    } edge_ev_t;

endpackage

// File: rtl/capt_regs.sv
// Module: register write port. It holds the mode register and the run bit,
// and it produces a one-cycle flag-clear request.
// Assumes single-cycle writes with no read path; unknown addresses are ignored.
module capt_regs
    import capt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output mode_t             mode_q,
    output logic              run_q,
    output logic              clr_req
);

    logic mode_wr;
    logic ctrl_wr;

    // Decode which register the current write targets.
    always_comb begin
        mode_wr = wr_en && (wr_addr == ADDR_MODE);
        ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
    end

    // Mode register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (mode_wr) begin
            mode_q <= mode_t'(wr_data[MODE_W-1:0]);
        end
    end

    // Timebase run enable storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else if (ctrl_wr) begin
            run_q <= wr_data[CTRL_RUN_BIT];
        end
    end

    // Writing 0 to the flag bit asks for a clear; writing 1 does nothing.
    always_comb begin
        clr_req = ctrl_wr && !wr_data[CTRL_FLAG_BIT];
    end

endmodule

// File: rtl/capt_timebase.sv
// Module: free-running timebase counter.
// Assumes the run enable is already synchronous; it wraps at 2**W.
module capt_timebase #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] ONE = W'(1);

    // Advance by one while enabled, wrapping naturally at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (run) begin
            count <= count + ONE;
        end
    end

endmodule

// File: rtl/capt_pin_filter.sv
// Module: input conditioner. A chain of synchroniser flops feeds a
// stability filter that accepts a level only after FILT_CYCLES matching
// samples in a row.
// Assumes pin is fully asynchronous; the filtered level resets low.
module capt_pin_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level
);

    localparam int CW = (FILT_CYCLES < 2) ? 1 : $clog2(FILT_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(FILT_CYCLES - 1);
    localparam logic [CW-1:0] CNT_ONE  = CW'(1);

    logic [SYNC_STAGES-1:0] chain;
    logic                   sync_lvl;
    logic [CW-1:0]          run_cnt;

    // Synchroniser stages; stage 0 samples the raw pin.
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            // First stage samples the asynchronous pin.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b0;
                else        chain[g] <= pin;
            end
        end else begin : g_next
            // Later stages take the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b0;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    // The last stage is the synchronised level.
    always_comb begin
        sync_lvl = chain[SYNC_STAGES-1];
    end

    // Count how long the synchronised level has differed from the accepted
    // one, and accept it once the count reaches the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            level   <= 1'b0;
        end else if (sync_lvl == level) begin
            run_cnt <= '0;
        end else if (run_cnt == CNT_LAST) begin
            run_cnt <= '0;
            level   <= sync_lvl;
        end else begin
            run_cnt <= run_cnt + CNT_ONE;
        end
    end

endmodule

// File: rtl/capt_edge_latch.sv
// Module: edge detector, capture register, sticky flag and interrupt gate.
// Assumes level is glitch-free and synchronous. A capture has priority over
// a clear that arrives in the same cycle.
module capt_edge_latch
    import capt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         level,
    input  logic         rise_en,
    input  logic         fall_en,
    input  logic         int_en,
    input  logic [W-1:0] stamp,
    input  logic         clr_req,
    output logic [W-1:0] cap_value,
    output logic         flag,
    output logic         irq
);

    logic     prev_lvl;
    edge_ev_t ev;
    logic     hit;

    // Remember the previous filtered level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_lvl <= 1'b0;
        else        prev_lvl <= level;
    end

    // Classify the transition and qualify it against the enables.
    always_comb begin
        if (level && !prev_lvl)      ev = EV_RISE;
        else if (!level && prev_lvl) ev = EV_FALL;
        else                         ev = EV_NONE;
        hit = ((ev == EV_RISE) && rise_en) || ((ev == EV_FALL) && fall_en);
    end

    // Load the timebase stamp on a qualified edge.
    always_ff @(posedge clk) begin
        if (!rst_n)   cap_value <= '0;
        else if (hit) cap_value <= stamp;
    end

    // Sticky flag: set by a capture, cleared only by a request.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (hit)     flag <= 1'b1;
        else if (clr_req) flag <= 1'b0;
    end

    // Interrupt request follows the flag when enabled.
    always_comb begin
        irq = flag && int_en;
    end

endmodule

// File: rtl/edge_capture_unit.sv
// Module: top of the edge-selectable capture channel. It joins the register
// port, the timebase, the input conditioner and the capture latch.
// Assumes one clock domain with a synchronous active-low reset.
module edge_capture_unit
    import capt_pkg::*;
#(
    parameter int TB_W        = 16,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [MODE_W-1:0] mode_q,
    output logic              run_q,
    output logic [TB_W-1:0]   timebase,
    output logic [TB_W-1:0]   cap_value,
    output logic              cap_flag,
    output logic              irq,
    output logic              pin_level
);

    mode_t mode_s;
    logic  clr_req;

    capt_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .mode_q  (mode_s),
        .run_q   (run_q),
        .clr_req (clr_req)
    );

    capt_timebase #(.W(TB_W)) u_tb (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_q),
        .count (timebase)
    );

    capt_pin_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .FILT_CYCLES (FILT_CYCLES)
    ) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (pin_in),
        .level (pin_level)
    );

    capt_edge_latch #(.W(TB_W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .level     (pin_level),
        .rise_en   (mode_s.rise_en),
        .fall_en   (mode_s.fall_en),
        .int_en    (mode_s.int_en),
        .stamp     (timebase),
        .clr_req   (clr_req),
        .cap_value (cap_value),
        .flag      (cap_flag),
        .irq       (irq)
    );

    // Present the mode register as a plain vector.
    always_comb begin
        mode_q = mode_s;
    end

endmodule

// File: rtl/edge_capture_chk.sv
// Checker: temporal properties of the capture unit, observed at its ports.
// Assumes it is bound to every instance of edge_capture_unit.
module edge_capture_chk #(
    parameter int TB_W        = 16,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYCLES = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pin_in,
    input logic            wr_en,
    input logic [1:0]      wr_addr,
    input logic [7:0]      wr_data,
    input logic [7:0]      mode_q,
    input logic            run_q,
    input logic [TB_W-1:0] timebase,
    input logic [TB_W-1:0] cap_value,
    input logic            cap_flag,
    input logic            irq,
    input logic            pin_level
);

    // R2
    tb_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run_q) |-> timebase == TB_W'($past(timebase) + TB_W'(1)));

    // R2
    tb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run_q) |-> $stable(timebase));

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cap_flag) |-> $past(wr_en && wr_addr == 2'd1 && !wr_data[0]));

    // R8
    flag_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_flag) |-> $past(pin_level) != $past(pin_level, 2));

    // R6
    no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!mode_q[5] && !mode_q[4]) |-> !$rose(cap_flag));

    // R11
    irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cap_flag);

    // R11
    irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_flag && mode_q[0]) |-> irq);

    // R12
    cap_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_value) |-> cap_flag);

    if (SYNC_STAGES == 2 && FILT_CYCLES == 2) begin : g_filt
        // R7
        level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(pin_level) |->
                (pin_level == $past(pin_in, 3)) && (pin_level == $past(pin_in, 4)));
    end

endmodule

bind edge_capture_unit edge_capture_chk #(
    .TB_W        (TB_W),
    .SYNC_STAGES (SYNC_STAGES),
    .FILT_CYCLES (FILT_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_in    (pin_in),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .mode_q    (mode_q),
    .run_q     (run_q),
    .timebase  (timebase),
    .cap_value (cap_value),
    .cap_flag  (cap_flag),
    .irq       (irq),
    .pin_level (pin_level)
);

// File: tb/sim_edge_capture_unit.sv
// Directed bench for edge_capture_unit: one task per scenario.
module sim_edge_capture_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [7:0]  wr_data = 8'd0;
    logic [7:0]  mode_q;
    logic        run_q;
    logic [15:0] timebase;
    logic [15:0] cap_value;
    logic        cap_flag;
    logic        irq;
    logic        pin_level;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    edge_capture_unit u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .mode_q    (mode_q),
        .run_q     (run_q),
        .timebase  (timebase),
        .cap_value (cap_value),
        .cap_flag  (cap_flag),
        .irq       (irq),
        .pin_level (pin_level)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Called at a negedge; the write is taken at the next posedge.
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 2'd0; wr_data = 8'd0;
    endtask

    task automatic clear_flag();
        wr(2'd1, 8'h02);
    endtask

    // Change the pin, then check the flag timing and the captured value (R8).
    task automatic drive_edge(input bit lvl, input bit hit, input string tag);
        logic [15:0] tb_exp;
        logic [15:0] cap_old;
        clear_flag();
        cap_old = cap_value;
        pin_in = lvl;
        tick(4);
        tb_exp = timebase;
        chk(cap_flag == 1'b0, {tag, " R8 flag early"}, cap_flag, 0);
        tick(1);
        if (hit) begin
            chk(cap_flag == 1'b1, {tag, " R8 flag set"}, cap_flag, 1);
            chk(cap_value == tb_exp, {tag, " R8 capture value"}, cap_value, tb_exp);
        end else begin
            chk(cap_flag == 1'b0, {tag, " no capture flag"}, cap_flag, 0);
            chk(cap_value == cap_old, {tag, " R12 value kept"}, cap_value, cap_old);
        end
        chk(pin_level == lvl, {tag, " R7 level status"}, pin_level, lvl);
        tick(2);
    endtask

    task automatic t_reset();
        chk(timebase == 16'd0, "R1 timebase", timebase, 0);
        chk(cap_value == 16'd0, "R1 capture", cap_value, 0);
        chk(cap_flag == 1'b0, "R1 flag", cap_flag, 0);
        chk(irq == 1'b0, "R1 irq", irq, 0);
        chk(mode_q == 8'd0, "R1 mode", mode_q, 0);
        chk(run_q == 1'b0, "R1 run", run_q, 0);
        chk(pin_level == 1'b0, "R1 level", pin_level, 0);
    endtask

    task automatic t_timebase();
        logic [15:0] a;
        tick(5);
        chk(timebase == 16'd0, "R2 idle hold", timebase, 0);
        wr(2'd1, 8'h02);
        chk(run_q == 1'b1, "R2 run set", run_q, 1);
        a = timebase;
        tick(10);
        chk(timebase == a + 16'd10, "R2 count", timebase, a + 16'd10);
        wr(2'd1, 8'h00);
        a = timebase;
        tick(7);
        chk(timebase == a, "R2 stopped hold", timebase, a);
        wr(2'd1, 8'h02);
    endtask

    task automatic t_rise();
        wr(2'd0, 8'h20);
        chk(mode_q == 8'h20, "R3 mode write", mode_q, 8'h20);
        drive_edge(1'b1, 1'b1, "R3 rise");
        drive_edge(1'b0, 1'b0, "R3 fall ignored");
    endtask

    task automatic t_fall();
        wr(2'd0, 8'h10);
        drive_edge(1'b1, 1'b0, "R4 rise ignored");
        drive_edge(1'b0, 1'b1, "R4 fall");
    endtask

    task automatic t_both();
        wr(2'd0, 8'h30);
        drive_edge(1'b1, 1'b1, "R5 rise");
        drive_edge(1'b0, 1'b1, "R5 fall");
    endtask

    task automatic t_none();
        wr(2'd0, 8'h00);
        drive_edge(1'b1, 1'b0, "R6 rise");
        drive_edge(1'b0, 1'b0, "R6 fall");
    endtask

    task automatic t_glitch();
        wr(2'd0, 8'h30);
        clear_flag();
        pin_in = 1'b1;
        tick(1);
        pin_in = 1'b0;
        tick(8);
        chk(cap_flag == 1'b0, "R7 short pulse flag", cap_flag, 0);
        chk(pin_level == 1'b0, "R7 short pulse level", pin_level, 0);
        pin_in = 1'b1;
        tick(2);
        pin_in = 1'b0;
        tick(2);
        chk(pin_level == 1'b1, "R7 two-clock pulse level", pin_level, 1);
        tick(1);
        chk(cap_flag == 1'b1, "R7 two-clock pulse captured", cap_flag, 1);
        tick(6);
        chk(pin_level == 1'b0, "R7 level returns low", pin_level, 0);
    endtask

    task automatic t_sticky();
        logic [15:0] c;
        drive_edge(1'b1, 1'b1, "R9 setup");
        c = cap_value;
        tick(20);
        chk(cap_flag == 1'b1, "R9 flag held", cap_flag, 1);
        chk(cap_value == c, "R12 value held", cap_value, c);
        wr(2'd1, 8'h03);
        chk(cap_flag == 1'b1, "R9 write one keeps flag", cap_flag, 1);
        chk(run_q == 1'b1, "R2 run kept", run_q, 1);
        wr(2'd2, 8'h00);
        chk(cap_flag == 1'b1, "R9 other address keeps flag", cap_flag, 1);
        wr(2'd1, 8'h02);
        chk(cap_flag == 1'b0, "R9 clear write", cap_flag, 0);
        chk(cap_value == c, "R12 value after clear", cap_value, c);
    endtask

    task automatic t_collide();
        logic [15:0] tb_exp;
        drive_edge(1'b0, 1'b1, "R10 setup");
        pin_in = 1'b1;
        tick(4);
        tb_exp = timebase;
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h02;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 2'd0; wr_data = 8'd0;
        chk(cap_flag == 1'b1, "R10 capture beats clear", cap_flag, 1);
        chk(cap_value == tb_exp, "R10 capture value", cap_value, tb_exp);
        clear_flag();
        chk(cap_flag == 1'b0, "R9 clear after collision", cap_flag, 0);
    endtask

    task automatic t_irq();
        wr(2'd0, 8'h31);
        chk(irq == 1'b0, "R11 no flag no irq", irq, 0);
        drive_edge(1'b0, 1'b1, "R11 setup");
        chk(irq == 1'b1, "R11 irq raised", irq, 1);
        wr(2'd0, 8'h30);
        chk(irq == 1'b0, "R11 irq masked", irq, 0);
        chk(cap_flag == 1'b1, "R11 flag kept while masked", cap_flag, 1);
        wr(2'd0, 8'h31);
        chk(irq == 1'b1, "R11 irq unmasked", irq, 1);
        clear_flag();
        chk(irq == 1'b0, "R11 irq after clear", irq, 0);
    endtask

    task automatic t_wrap();
        int guard;
        guard = 0;
        while (timebase != 16'hFFF0 && guard < 70000) begin
            tick(1);
            guard++;
        end
        chk(timebase == 16'hFFF0, "R2 reach top", timebase, 16'hFFF0);
        tick(15);
        chk(timebase == 16'hFFFF, "R2 at top", timebase, 16'hFFFF);
        tick(1);
        chk(timebase == 16'h0000, "R2 wrap", timebase, 0);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_timebase();
        t_rise();
        t_fall();
        t_both();
        t_none();
        t_glitch();
        t_sticky();
        t_collide();
        t_irq();
        t_wrap();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule